// File: doc/BRIEF.md
# Programmable Sinc3 Decimation Filter

This block turns the one-bit output stream of a delta-sigma modulator into wide output words. Three running sums feed three differencing stages, so the response is a sinc function cubed. The decimation ratio is set at runtime by a 12-bit rate code. Each unit of the code is worth `STEP_CYCLES` input clocks, which is 512 by default. The word rate and the first notch therefore both equal the clock divided by `STEP_CYCLES` and then by the code. Codes below 19 or above 2000 are clamped to the nearest limit.

The output word is the raw filter sum at full width. For a steady input the settled word equals R cubed times the density of ones, where R is the ratio in clocks. A one-cycle ready pulse marks each word that the host may use. Ready pulses are held back until the filter has settled.
- After a filter restart, a channel change or a reset, the first pulse comes with the third word.
- After a code change that is not tied to a restart, the first pulse comes with the fourth word at the new ratio.
- With background calibration on, only every sixth word is published, so the published rate drops by six.

Top module: `sinc3_decim`

## Requirements
- R1: During and straight after reset, `word_rdy` is 0 and `word_out` is 0. The first word after reset is built with the default code 65, whatever value sits on `rate_code`.
- R2: In steady operation, `word_rdy` pulses once every R clocks, where R is the clamped `rate_code` times `STEP_CYCLES`.
- R3: A `rate_code` below 19 acts as 19, and one above 2000 acts as 2000.
- R4: Once settled, with a steady input pattern whose period divides R, `word_out` equals R^3 times the fraction of ones. This gives R^3 for all ones, 0 for all zeros, R^3/2 for an alternating 1/0 stream and R^3/4 for one 1 in every 4 bits.
- R5: A cycle with `flt_sync` high clears the filter state and the output word, and loads the ratio from `rate_code` at once. The first `word_rdy` follows 3R clocks after that cycle.
- R6: A cycle with `chan_step` high has exactly the same effect as `flt_sync`, with its first ready pulse 3R clocks later.
- R7: `rate_code` is sampled only at word boundaries. When the sampled ratio differs from the running ratio, the finished word is not flagged, and the next `word_rdy` comes 4 new-ratio periods after that boundary. The gap from the last pulse is therefore R_old + 4·R_new.
- R8: `word_rdy` is never high on two consecutive cycles. It is high only in the cycle after a word boundary.
- R9: With `bg_cal_en` high from a restart onward, `word_rdy` first pulses 6R clocks after the restart and then every 6R clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator bitstream, one bit per clock |
| rate_code | input | 12 | Decimation code; ratio = clamp(code) × STEP_CYCLES |
| flt_sync | input | 1 | Synchronous filter restart, active high |
| chan_step | input | 1 | Channel-change strobe, restarts the filter |
| bg_cal_en | input | 1 | Background calibration: publish every 6th word |
| word_out | output | ACC_W | Filter output word, 3·RATIO_W+1 bits |
| word_rdy | output | 1 | One-cycle flag for a settled, published word |

## Verification
The hardest case to reach is an unsynchronised code change. Its four-word hold-off starts at an internal word boundary that cannot be seen at the ports. The bench changes the code just after a ready pulse, so the boundary lies exactly one old period later, and then checks the gap R_old + 4·R_new. The bench builds the filter with a small `STEP_CYCLES`, so that even the clamped top code and the six-fold background cadence settle within a short run.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int CODE_W      = 12;
  localparam int CODE_LO     = 19;
  localparam int CODE_HI     = 2000;
  localparam int CODE_DEF    = 65;
  localparam int STAGES      = 3;
  localparam int SETTLE_SYNC = 3;
  localparam int SETTLE_FREE = 4;
  localparam int BG_DIV      = 6;
  localparam int LEFT_W      = 3;
  localparam int SLOT_W      = 3;

  // limit a raw rate code to the supported window
  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    if (int'(c) < CODE_LO)      return CODE_W'(CODE_LO);
    else if (int'(c) > CODE_HI) return CODE_W'(CODE_HI);
    else                        return c;
  endfunction

  // bits needed to hold the largest ratio for a given step size
  function automatic int ratio_bits(input int step);
    return $clog2(CODE_HI * step + 1);
  endfunction
endpackage

// File: rtl/sinc3_rate_ctrl.sv
module sinc3_rate_ctrl
  import sinc3_pkg::*;
#(
  parameter int STEP_CYCLES = 512,
  parameter int RATIO_W     = ratio_bits(STEP_CYCLES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [CODE_W-1:0]  code_in,
  output logic               word_stb,
  output logic               ratio_chg,
  output logic [RATIO_W-1:0] ratio_act
);
  localparam logic [RATIO_W-1:0] RATIO_DEF = RATIO_W'(CODE_DEF * STEP_CYCLES);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] ratio_req;

  always_comb begin
    ratio_req = RATIO_W'(32'(clamp_code(code_in)) * 32'(STEP_CYCLES));
  end

  assign word_stb  = !restart && (cnt_q == ratio_q - RATIO_W'(1));
  assign ratio_chg = word_stb && (ratio_req != ratio_q);
  assign ratio_act = ratio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_DEF;
    end else if (restart) begin
      cnt_q   <= '0;
      ratio_q <= ratio_req;
    end else if (word_stb) begin
      cnt_q   <= '0;
      ratio_q <= ratio_req;
    end else begin
      cnt_q   <= cnt_q + RATIO_W'(1);
    end
  end
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 61
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_in,
  output logic [ACC_W-1:0] sum_next
);
  logic [ACC_W-1:0] acc_q [STAGES];
  logic [ACC_W-1:0] acc_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign acc_d[g] = acc_q[g] + ACC_W'(bit_in);
    end else begin : g_rest
      assign acc_d[g] = acc_q[g] + acc_d[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr) acc_q[g] <= '0;
      else            acc_q[g] <= acc_d[g];
    end
  end

  assign sum_next = acc_d[STAGES-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 61
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             stb,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] word_q
);
  logic [ACC_W-1:0] dly_q [STAGES];
  logic [ACC_W-1:0] stg_in [STAGES];
  logic [ACC_W-1:0] dif [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stg_in[g] = din;
    end else begin : g_rest
      assign stg_in[g] = dif[g-1];
    end
    assign dif[g] = stg_in[g] - dly_q[g];
    always_ff @(posedge clk) begin
      if (rst || clr) dly_q[g] <= '0;
      else if (stb)   dly_q[g] <= stg_in[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) word_q <= '0;
    else if (stb)   word_q <= dif[STAGES-1];
  end
endmodule

// File: rtl/sinc3_settle.sv
module sinc3_settle
  import sinc3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic word_stb,
  input  logic ratio_chg,
  input  logic bg_en,
  output logic rdy_q
);
  logic [LEFT_W-1:0] left_q;
  logic [SLOT_W-1:0] slot_q;
  logic              settled;
  logic              slot_open;

  assign settled   = (left_q <= LEFT_W'(1));
  assign slot_open = !bg_en || (slot_q == SLOT_W'(BG_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      left_q <= LEFT_W'(SETTLE_SYNC);
      slot_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      if (word_stb) begin
        slot_q <= (slot_q == SLOT_W'(BG_DIV - 1)) ? '0 : slot_q + SLOT_W'(1);
        if (ratio_chg) begin
          left_q <= LEFT_W'(SETTLE_FREE);
        end else begin
          rdy_q <= settled && slot_open;
          if (left_q != '0) left_q <= left_q - LEFT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int STEP_CYCLES = 512,
  parameter int RATIO_W     = ratio_bits(STEP_CYCLES),
  parameter int ACC_W       = STAGES * RATIO_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_bit,
  input  logic [11:0]       rate_code,
  input  logic              flt_sync,
  input  logic              chan_step,
  input  logic              bg_cal_en,
  output logic [ACC_W-1:0]  word_out,
  output logic              word_rdy
);
  logic               restart;
  logic               word_stb;
  logic               ratio_chg;
  logic [RATIO_W-1:0] ratio_act;
  logic [ACC_W-1:0]   integ_sum;

  assign restart = flt_sync || chan_step;

  sinc3_rate_ctrl #(.STEP_CYCLES(STEP_CYCLES), .RATIO_W(RATIO_W)) u_rate (
    .clk(clk), .rst(rst), .restart(restart), .code_in(rate_code),
    .word_stb(word_stb), .ratio_chg(ratio_chg), .ratio_act(ratio_act)
  );

  sinc3_integ #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .clr(restart), .bit_in(mod_bit), .sum_next(integ_sum)
  );

  sinc3_comb #(.ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst(rst), .clr(restart), .stb(word_stb), .din(integ_sum),
    .word_q(word_out)
  );

  sinc3_settle u_settle (
    .clk(clk), .rst(rst), .restart(restart), .word_stb(word_stb),
    .ratio_chg(ratio_chg), .bg_en(bg_cal_en), .rdy_q(word_rdy)
  );
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk
  import sinc3_pkg::*;
#(
  parameter int STEP_CYCLES = 512,
  parameter int RATIO_W     = ratio_bits(STEP_CYCLES),
  parameter int ACC_W       = STAGES * RATIO_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               flt_sync,
  input logic               chan_step,
  input logic [ACC_W-1:0]   word_out,
  input logic               word_rdy,
  input logic               word_stb,
  input logic               ratio_chg,
  input logic [RATIO_W-1:0] ratio_act
);
  localparam logic [RATIO_W-1:0] R_LO = RATIO_W'(CODE_LO * STEP_CYCLES);
  localparam logic [RATIO_W-1:0] R_HI = RATIO_W'(CODE_HI * STEP_CYCLES);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_rdy |=> !word_rdy);

  a_r8_rdy_after_boundary: assert property (@(posedge clk) disable iff (rst)
    word_rdy |-> $past(word_stb));

  a_r5_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    (flt_sync || chan_step) |=> !word_rdy);

  a_r7_change_suppressed: assert property (@(posedge clk) disable iff (rst)
    ratio_chg |=> !word_rdy);

  a_r3_ratio_window: assert property (@(posedge clk) disable iff (rst)
    (ratio_act >= R_LO) && (ratio_act <= R_HI));

  a_r4_word_held: assert property (@(posedge clk) disable iff (rst)
    (!word_stb && !flt_sync && !chan_step) |=> $stable(word_out));
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .STEP_CYCLES(STEP_CYCLES), .RATIO_W(RATIO_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .flt_sync(flt_sync), .chan_step(chan_step),
  .word_out(word_out), .word_rdy(word_rdy), .word_stb(word_stb),
  .ratio_chg(ratio_chg), .ratio_act(ratio_act)
);

// File: tb/test_sinc3_decim.sv
`timescale 1ns/1ps
module test_sinc3_decim;
  localparam int STEP = 4;
  localparam int RW   = $clog2(2000 * STEP + 1);
  localparam int AW   = 3 * RW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mod_bit;
  logic [11:0]   rate_code = 12'd100;
  logic          flt_sync = 1'b0;
  logic          chan_step = 1'b0;
  logic          bg_cal_en = 1'b0;
  logic [AW-1:0] word_out;
  logic          word_rdy;

  int n_chk = 0;
  int n_bad = 0;
  int pat_mode = 0;

  always #10 clk = ~clk;

  sinc3_decim #(.STEP_CYCLES(STEP)) i_sinc3_decim (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .rate_code(rate_code),
    .flt_sync(flt_sync), .chan_step(chan_step), .bg_cal_en(bg_cal_en),
    .word_out(word_out), .word_rdy(word_rdy)
  );

  // bitstream source: 0 zeros, 1 ones, 2 alternating, 3 one in four
  initial begin
    int ph;
    ph = 0;
    mod_bit = 1'b0;
    forever begin
      @(negedge clk);
      ph++;
      case (pat_mode)
        0: mod_bit = 1'b0;
        1: mod_bit = 1'b1;
        2: mod_bit = ph[0];
        default: mod_bit = (ph % 4 == 0);
      endcase
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!word_rdy && n < 40000);
  endtask

  task automatic restart_with(input int code, input bit use_chan);
    @(negedge clk);
    rate_code = 12'(code);
    if (use_chan) chan_step = 1'b1; else flt_sync = 1'b1;
    @(negedge clk);
    chan_step = 1'b0;
    flt_sync  = 1'b0;
  endtask

  function automatic longint cube(input longint r);
    return r * r * r;
  endfunction

  task automatic t_reset_default;
    int n;
    rate_code = 12'd100;
    pat_mode = 1;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset rdy", word_rdy, 0);
    chk("R1 reset word", longint'(word_out), 0);
    wait_rdy(n);
    // default word 65*STEP, then code change to 100 needs 4 new periods
    chk("R1 default first word", n, 65 * STEP + 4 * 100 * STEP);
  endtask

  task automatic t_ones;
    int n;
    pat_mode = 1;
    restart_with(19, 0);
    wait_rdy(n);
    chk("R5 sync settle", n, 3 * 19 * STEP);
    chk("R4 ones value", longint'(word_out), cube(19 * STEP));
    wait_rdy(n);
    chk("R2 word period", n, 19 * STEP);
    @(posedge clk); @(negedge clk);
    chk("R8 rdy single cycle", word_rdy, 0);
  endtask

  task automatic t_zeros;
    int n;
    pat_mode = 0;
    restart_with(19, 0);
    wait_rdy(n);
    chk("R4 zeros value", longint'(word_out), 0);
  endtask

  task automatic t_alt;
    int n;
    pat_mode = 2;
    restart_with(50, 0);
    wait_rdy(n);
    chk("R5 sync settle code 50", n, 3 * 50 * STEP);
    chk("R4 alternating value", longint'(word_out), cube(50 * STEP) / 2);
  endtask

  task automatic t_quarter;
    int n;
    pat_mode = 3;
    restart_with(25, 0);
    wait_rdy(n);
    chk("R4 quarter density value", longint'(word_out), cube(25 * STEP) / 4);
  endtask

  task automatic t_chan;
    int n;
    pat_mode = 1;
    restart_with(19, 1);
    wait_rdy(n);
    chk("R6 channel change settle", n, 3 * 19 * STEP);
    chk("R6 channel change value", longint'(word_out), cube(19 * STEP));
  endtask

  task automatic t_code_change;
    int n;
    pat_mode = 1;
    restart_with(19, 0);
    wait_rdy(n);
    rate_code = 12'd50;
    wait_rdy(n);
    chk("R7 unsynced change gap", n, 19 * STEP + 4 * 50 * STEP);
    chk("R7 value after change", longint'(word_out), cube(50 * STEP));
    wait_rdy(n);
    chk("R7 new period", n, 50 * STEP);
  endtask

  task automatic t_clamp_low;
    int n;
    pat_mode = 1;
    restart_with(3, 0);
    wait_rdy(n);
    chk("R3 clamp low settle", n, 3 * 19 * STEP);
    wait_rdy(n);
    chk("R3 clamp low period", n, 19 * STEP);
  endtask

  task automatic t_clamp_high;
    int n;
    pat_mode = 1;
    restart_with(4095, 0);
    wait_rdy(n);
    chk("R3 clamp high settle", n, 3 * 2000 * STEP);
    chk("R3 clamp high value", longint'(word_out), cube(2000 * STEP));
    wait_rdy(n);
    chk("R3 clamp high period", n, 2000 * STEP);
  endtask

  task automatic t_bg;
    int n;
    pat_mode = 1;
    bg_cal_en = 1'b1;
    restart_with(19, 0);
    wait_rdy(n);
    chk("R9 background first word", n, 6 * 19 * STEP);
    chk("R9 background value", longint'(word_out), cube(19 * STEP));
    wait_rdy(n);
    chk("R9 background period", n, 6 * 19 * STEP);
    bg_cal_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset_default();
    t_ones();
    t_zeros();
    t_alt();
    t_quarter();
    t_chan();
    t_code_change();
    t_clamp_low();
    t_clamp_high();
    t_bg();
    finish_run();
  end
endmodule